// File: doc/BRIEF.md
# Drive Power-Mode State Controller

This block holds the power state of a storage drive (Sleep, Standby, Idle or Active) and moves between them on decoded host commands and on an inactivity timeout. Each command arrives as a one-cycle strobe carrying an opcode byte and the count value that the host wrote with it. For the timer-setting commands, that count gives the inactivity interval in units of five seconds.

The timer counts a prescaled tick supplied by the surrounding logic. `TICKS_PER_UNIT` ticks make up one five-second unit, so a simulation can shrink the unit to a few ticks. The block drives a spindle-enable output and answers a power-mode query with a one-byte status. It does not control the motor, access the media or hold the host register file.

Top module: `drive_pwr_ctrl`

## Requirements
- R1: A low `rst_n` or a high `soft_rst` puts the block in Standby (`pwr_state` = 1, `spin_en` = 0) and clears the programmed interval to zero. Neither reset raises `stat_valid`.
- R2: Opcode 97h or E3h moves the block to Idle (`pwr_state` = 2, `spin_en` = 1), spinning up from Standby if needed, and stores `cmd_count` as the new interval.
- R3: While the block is Idle or Active with a nonzero interval N, it enters Standby on exactly the N*`TICKS_PER_UNIT`-th `unit_tick` after the last accepted command, provided no further command arrives.
- R4: An interval of zero disables the timer. Idle or Active then lasts for any number of ticks.
- R5: Every accepted command reloads the countdown with the full programmed interval.
- R6: Opcode 98h or E5h leaves the state unchanged. One cycle after the strobe it raises `stat_valid` for one cycle, with `stat_byte` = FFh if the block was Idle or Active and 00h if it was Standby.
- R7: Opcode 99h or E6h enters Sleep (`pwr_state` = 0, `spin_en` = 0). In Sleep every strobe is ignored: there is no state change, no status response and no timer reload. Only a reset leaves Sleep, and it lands in Standby.
- R8: Any opcode outside the power-management set moves the block from Idle or Standby to Active (`pwr_state` = 3, `spin_en` = 1).
- R9: Opcodes 96h or E2h move the block to Standby and store `cmd_count` as the interval. Opcodes 94h or E0h move it to Standby and leave the interval alone. Opcodes 95h or E1h move it to Idle and leave the interval alone.
- R10: `spin_en` is high exactly when `pwr_state` is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | COUNT_W | Count value written with the command |
| unit_tick | input | 1 | Prescaled timebase tick |
| pwr_state | output | 2 | 0 Sleep, 1 Standby, 2 Idle, 3 Active |
| spin_en | output | 1 | Spindle enable |
| stat_valid | output | 1 | Power-mode query response strobe |
| stat_byte | output | 8 | Power-mode query response value |

## Verification
On every cycle, assertions check the following:
- Sleep stays in place until a reset arrives.
- A software reset lands in Standby.
- A media command lands in Active.
- A timer expiry drops the block to Standby.
- A query leaves the state unchanged.
- The countdown never exceeds the programmed interval.
- A zero interval never expires.

The exact tick on which the timeout fires, the effect of restarts from each command class, and the status byte values can only be shown by the bench scenarios. Those scenarios compare the outputs against a behavioural model driven by the same random and directed stimulus.

// File: rtl/pm_pkg.sv
package pm_pkg;

   localparam int OP_W = 8;

   typedef enum logic [1:0] {
      PS_SLEEP   = 2'd0,
      PS_STANDBY = 2'd1,
      PS_IDLE    = 2'd2,
      PS_ACTIVE  = 2'd3
   } pstate_e;

   typedef enum logic [2:0] {
      CC_MEDIA,
      CC_IDLE_TMR,
      CC_IDLE_NOW,
      CC_STBY_TMR,
      CC_STBY_NOW,
      CC_QUERY,
      CC_SLEEP
   } cclass_e;

   localparam logic [OP_W-1:0] OP_IDLE_TMR_A = 8'h97;
   localparam logic [OP_W-1:0] OP_IDLE_TMR_B = 8'hE3;
   localparam logic [OP_W-1:0] OP_IDLE_NOW_A = 8'h95;
   localparam logic [OP_W-1:0] OP_IDLE_NOW_B = 8'hE1;
   localparam logic [OP_W-1:0] OP_STBY_TMR_A = 8'h96;
   localparam logic [OP_W-1:0] OP_STBY_TMR_B = 8'hE2;
   localparam logic [OP_W-1:0] OP_STBY_NOW_A = 8'h94;
   localparam logic [OP_W-1:0] OP_STBY_NOW_B = 8'hE0;
   localparam logic [OP_W-1:0] OP_QUERY_A    = 8'h98;
   localparam logic [OP_W-1:0] OP_QUERY_B    = 8'hE5;
   localparam logic [OP_W-1:0] OP_SLEEP_A    = 8'h99;
   localparam logic [OP_W-1:0] OP_SLEEP_B    = 8'hE6;

   localparam logic [OP_W-1:0] STAT_SPUN = 8'hFF;
   localparam logic [OP_W-1:0] STAT_DOWN = 8'h00;

   function automatic logic is_spun(input pstate_e s);
      return (s == PS_IDLE) || (s == PS_ACTIVE);
   endfunction

endpackage

// File: rtl/pm_cmd_decode.sv
module pm_cmd_decode
   import pm_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output cclass_e         cls
);
   always_comb begin
      unique case (op)
         OP_IDLE_TMR_A, OP_IDLE_TMR_B: cls = CC_IDLE_TMR;
         OP_IDLE_NOW_A, OP_IDLE_NOW_B: cls = CC_IDLE_NOW;
         OP_STBY_TMR_A, OP_STBY_TMR_B: cls = CC_STBY_TMR;
         OP_STBY_NOW_A, OP_STBY_NOW_B: cls = CC_STBY_NOW;
         OP_QUERY_A,    OP_QUERY_B:    cls = CC_QUERY;
         OP_SLEEP_A,    OP_SLEEP_B:    cls = CC_SLEEP;
         default:                      cls = CC_MEDIA;
      endcase
   end
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
   parameter int COUNT_W        = 8,
   parameter int TICKS_PER_UNIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               load_cfg,
   input  logic [COUNT_W-1:0] cfg_in,
   input  logic               restart,
   input  logic               run,
   input  logic               tick,
   output logic               expire
);
   localparam int UNIT_W = $clog2(TICKS_PER_UNIT + 1);
   localparam int CNT_W  = COUNT_W + UNIT_W;
   localparam logic [CNT_W-1:0] TPU_V = CNT_W'(TICKS_PER_UNIT);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   logic [COUNT_W-1:0] cfg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [COUNT_W-1:0] cfg_eff;
   logic [CNT_W-1:0]   reload_val;
   logic               enabled;

   assign cfg_eff = load_cfg ? cfg_in : cfg_q;
   assign enabled = (cfg_q != '0);

   generate
      if (TICKS_PER_UNIT == 1) begin : g_unit_direct
         assign reload_val = CNT_W'(cfg_eff);
      end else begin : g_unit_scaled
         assign reload_val = CNT_W'(cfg_eff) * TPU_V;
      end
   endgenerate

   assign expire = run && tick && !restart && !clr && enabled && (cnt_q == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         cfg_q <= '0;
         cnt_q <= '0;
      end else begin
         if (load_cfg) cfg_q <= cfg_in;
         if (restart) begin
            cnt_q <= reload_val;
         end else if (run && tick && enabled && (cnt_q > ONE_V)) begin
            cnt_q <= cnt_q - ONE_V;
         end
      end
   end

   AST_ZERO_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q == '0) |-> !expire); // R4
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(cfg_q) * TPU_V); // R5
endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
   import pm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sw_reset,
   input  logic    cmd_valid,
   input  cclass_e cls,
   input  logic    expire,
   output logic    accept,
   output pstate_e state
);
   pstate_e state_q, state_d;

   assign accept = cmd_valid && !sw_reset && (state_q != PS_SLEEP);
   assign state  = state_q;

   always_comb begin
      state_d = state_q;
      if (sw_reset) begin
         state_d = PS_STANDBY;
      end else if (accept) begin
         unique case (cls)
            CC_IDLE_TMR, CC_IDLE_NOW: state_d = PS_IDLE;
            CC_STBY_TMR, CC_STBY_NOW: state_d = PS_STANDBY;
            CC_SLEEP:                 state_d = PS_SLEEP;
            CC_MEDIA:                 state_d = PS_ACTIVE;
            default:                  state_d = state_q;
         endcase
      end else if (expire) begin
         state_d = PS_STANDBY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_STANDBY;
      else        state_q <= state_d;
   end

   AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SLEEP && !sw_reset) |=> (state_q == PS_SLEEP)); // R7
   AST_SWRST_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> (state_q == PS_STANDBY)); // R1
   AST_MEDIA_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cls == CC_MEDIA) |=> (state_q == PS_ACTIVE)); // R8
   AST_EXPIRE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !cmd_valid && !sw_reset) |=> (state_q == PS_STANDBY)); // R3
   AST_QUERY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cls == CC_QUERY) |=> $stable(state_q)); // R6
endmodule

// File: rtl/pm_query_resp.sv
module pm_query_resp
   import pm_pkg::*;
#(
   parameter bit QUERY_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            fire,
   input  logic            spun,
   output logic            q_valid,
   output logic [OP_W-1:0] q_byte
);
   generate
      if (QUERY_REG) begin : g_registered
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_byte  <= STAT_DOWN;
            end else begin
               q_valid <= fire && !clr;
               if (fire) q_byte <= spun ? STAT_SPUN : STAT_DOWN;
            end
         end
      end else begin : g_direct
         assign q_valid = fire && !clr;
         assign q_byte  = spun ? STAT_SPUN : STAT_DOWN;
      end
   endgenerate

   AST_QUERY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> (q_byte == STAT_SPUN || q_byte == STAT_DOWN)); // R6
endmodule

// File: rtl/drive_pwr_ctrl.sv
module drive_pwr_ctrl
   import pm_pkg::*;
#(
   parameter int COUNT_W        = 8,
   parameter int TICKS_PER_UNIT = 4,
   parameter bit QUERY_REG      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               cmd_stb,
   input  logic [7:0]         cmd_op,
   input  logic [COUNT_W-1:0] cmd_count,
   input  logic               unit_tick,
   output logic [1:0]         pwr_state,
   output logic               spin_en,
   output logic               stat_valid,
   output logic [7:0]         stat_byte
);
   initial begin
      assert (COUNT_W >= 1 && COUNT_W <= 24)
         else $error("COUNT_W out of range");
      assert (TICKS_PER_UNIT >= 1 && TICKS_PER_UNIT <= 65536)
         else $error("TICKS_PER_UNIT out of range");
   end

   cclass_e cls;
   pstate_e state;
   logic    accept, expire, spun, load_cfg;

   pm_cmd_decode u_dec (
      .op  (cmd_op),
      .cls (cls)
   );

   assign spun     = is_spun(state);
   assign load_cfg = accept && (cls == CC_IDLE_TMR || cls == CC_STBY_TMR);

   pm_idle_timer #(
      .COUNT_W        (COUNT_W),
      .TICKS_PER_UNIT (TICKS_PER_UNIT)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .load_cfg (load_cfg),
      .cfg_in   (cmd_count),
      .restart  (accept),
      .run      (spun),
      .tick     (unit_tick),
      .expire   (expire)
   );

   pm_state_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_reset  (soft_rst),
      .cmd_valid (cmd_stb),
      .cls       (cls),
      .expire    (expire),
      .accept    (accept),
      .state     (state)
   );

   pm_query_resp #(
      .QUERY_REG (QUERY_REG)
   ) u_qry (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_rst),
      .fire    (accept && cls == CC_QUERY),
      .spun    (spun),
      .q_valid (stat_valid),
      .q_byte  (stat_byte)
   );

   assign pwr_state = state;
   assign spin_en   = spun;
endmodule

// File: tb/drive_pwr_ctrl_tb.sv
module drive_pwr_ctrl_tb;
   localparam int TPU = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       cmd_stb = 1'b0;
   logic [7:0] cmd_op = 8'h00;
   logic [7:0] cmd_count = 8'h00;
   logic       unit_tick = 1'b0;
   logic [1:0] pwr_state;
   logic       spin_en;
   logic       stat_valid;
   logic [7:0] stat_byte;

   always #10 clk = ~clk;

   drive_pwr_ctrl #(.COUNT_W(8), .TICKS_PER_UNIT(TPU), .QUERY_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_stb(cmd_stb),
      .cmd_op(cmd_op), .cmd_count(cmd_count), .unit_tick(unit_tick),
      .pwr_state(pwr_state), .spin_en(spin_en),
      .stat_valid(stat_valid), .stat_byte(stat_byte)
   );

   int unsigned n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // behavioural model: 0 sleep, 1 standby, 2 idle, 3 active
   int       m_st = 1, m_cfg = 0, m_cnt = 0;
   bit       m_qv = 1'b0;
   bit [7:0] m_qb = 8'h00;

   // 0 media,1 idle+timer,2 idle now,3 standby+timer,4 standby now,5 query,6 sleep
   function automatic int op_kind(input bit [7:0] op);
      case (op)
         8'h97, 8'hE3: return 1;
         8'h95, 8'hE1: return 2;
         8'h96, 8'hE2: return 3;
         8'h94, 8'hE0: return 4;
         8'h98, 8'hE5: return 5;
         8'h99, 8'hE6: return 6;
         default:      return 0;
      endcase
   endfunction

   task automatic model_step(input bit c, input bit [7:0] op, input bit [7:0] n,
                             input bit tk, input bit sr);
      int k;
      m_qv = 1'b0;
      if (sr) begin
         m_st = 1; m_cfg = 0; m_cnt = 0;
      end else if (m_st == 0) begin
         // sleep ignores everything
      end else if (c) begin
         k = op_kind(op);
         if (k == 1 || k == 3) m_cfg = n;
         m_cnt = m_cfg * TPU;
         case (k)
            0: m_st = 3;
            1, 2: m_st = 2;
            3, 4: m_st = 1;
            5: begin m_qv = 1'b1; m_qb = (m_st >= 2) ? 8'hFF : 8'h00; end
            6: m_st = 0;
            default: ;
         endcase
      end else if (tk && m_st >= 2 && m_cfg != 0) begin
         if (m_cnt == 1) m_st = 1;
         else m_cnt = m_cnt - 1;
      end
   endtask

   task automatic compare(input string tag);
      bit ok;
      ok = (pwr_state == 2'(m_st)) && (spin_en == (m_st >= 2)) && (stat_valid == m_qv)
           && (!m_qv || stat_byte == m_qb);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: state=%0d spin=%0b sv=%0b sb=%02h expected state=%0d spin=%0b sv=%0b sb=%02h",
                  tag, pwr_state, spin_en, stat_valid, stat_byte, m_st, (m_st >= 2), m_qv, m_qb);
      end
   endtask

   task automatic expect_lit(input string tag, input int st, input bit qv, input bit [7:0] qb);
      n_chk++;
      if (pwr_state != 2'(st) || spin_en != (st >= 2) || stat_valid != qv || (qv && stat_byte != qb)) begin
         n_bad++;
         $display("FAIL %s: state=%0d spin=%0b sv=%0b sb=%02h expected state=%0d sv=%0b sb=%02h",
                  tag, pwr_state, spin_en, stat_valid, stat_byte, st, qv, qb);
      end
   endtask

   // compare the current outputs, then apply one cycle of stimulus
   task automatic step(input bit c, input bit [7:0] op, input bit [7:0] n,
                       input bit tk, input bit sr, input string tag);
      @(negedge clk);
      compare(tag);
      cmd_stb = c; cmd_op = op; cmd_count = n; unit_tick = tk; soft_rst = sr;
      model_step(c, op, n, tk, sr);
   endtask

   task automatic cmd(input bit [7:0] op, input bit [7:0] n, input string tag);
      step(1'b1, op, n, 1'b0, 1'b0, tag);
   endtask

   task automatic ticks(input int k, input string tag);
      for (int i = 0; i < k; i++) step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, tag);
   endtask

   task automatic settle(input string tag);
      step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, tag);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      bit [7:0] ops [15] = '{8'h97, 8'hE3, 8'h95, 8'hE1, 8'h96, 8'hE2, 8'h94, 8'hE0,
                             8'h98, 8'hE5, 8'h99, 8'hE6, 8'h20, 8'h30, 8'hC8};
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      expect_lit("R1 hw reset", 1, 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      expect_lit("R1 after release", 1, 1'b0, 8'h00);

      cmd(8'h97, 8'd2, "R2");
      settle("R2 idle"); expect_lit("R2 idle lit", 2, 1'b0, 8'h00);
      ticks(7, "R3 before");
      settle("R3 pre-expire"); expect_lit("R3 still idle", 2, 1'b0, 8'h00);
      ticks(1, "R3 expire");
      settle("R3 expired"); expect_lit("R3 standby", 1, 1'b0, 8'h00);

      cmd(8'hE3, 8'd0, "R4");
      ticks(40, "R4 disabled");
      settle("R4"); expect_lit("R4 still idle", 2, 1'b0, 8'h00);

      cmd(8'hE3, 8'd1, "R5");
      ticks(3, "R5");
      cmd(8'h20, 8'd0, "R8 media restart");
      ticks(3, "R5 restarted");
      settle("R5"); expect_lit("R5 active", 3, 1'b0, 8'h00);
      ticks(1, "R5 expire");
      settle("R5"); expect_lit("R5 standby", 1, 1'b0, 8'h00);

      cmd(8'h98, 8'd0, "R6 query standby");
      @(negedge clk); expect_lit("R6 byte 00", 1, 1'b1, 8'h00); compare("R6");
      cmd(8'h30, 8'd0, "R8 spin up");
      cmd(8'hE5, 8'd0, "R6 query active");
      @(negedge clk); expect_lit("R6 byte FF", 3, 1'b1, 8'hFF); compare("R6");

      cmd(8'h96, 8'd3, "R9 standby timer");
      cmd(8'h95, 8'd0, "R9 idle now");
      settle("R9"); expect_lit("R9 idle", 2, 1'b0, 8'h00);
      ticks(11, "R9 keeps cfg");
      settle("R9"); expect_lit("R9 idle 11", 2, 1'b0, 8'h00);
      ticks(1, "R9 expire");
      cmd(8'hE1, 8'd0, "R9");
      cmd(8'hE0, 8'd5, "R9 standby now");
      settle("R9"); expect_lit("R9 standby lit", 1, 1'b0, 8'h00);

      cmd(8'h97, 8'd1, "R7 prep");
      cmd(8'h99, 8'd0, "R7 sleep");
      settle("R7"); expect_lit("R7 sleep lit", 0, 1'b0, 8'h00);
      cmd(8'h20, 8'd0, "R7 media ignored");
      cmd(8'h98, 8'd0, "R7 query ignored");
      ticks(10, "R7");
      settle("R7"); expect_lit("R7 still sleep", 0, 1'b0, 8'h00);
      step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, "R7 soft reset");
      settle("R7"); expect_lit("R7 wake standby", 1, 1'b0, 8'h00);
      cmd(8'h95, 8'd0, "R1 cfg cleared");
      ticks(20, "R1 no timeout");
      settle("R1"); expect_lit("R1 idle kept", 2, 1'b0, 8'h00);
      cmd(8'hE6, 8'd0, "R10 sleep");
      settle("R10"); expect_lit("R10 code 0", 0, 1'b0, 8'h00);
      rst_n = 1'b0;
      model_step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
      @(negedge clk); expect_lit("R7 hw reset wakes", 1, 1'b0, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < 3000; i++) begin
         bit c, sr;
         c  = ($urandom % 6) == 0;
         sr = ($urandom % 80) == 0;
         step(c, ops[$urandom % 15], 8'($urandom % 4), ($urandom % 2) == 1, sr, "R10 random");
      end
      settle("R10 random end");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule